// File: doc/BRIEF.md
# Memory Diagnostic Error Capture Registers

This block collects error reports raised while a memory is being exercised in a diagnostic test mode. An ECC or parity checker next to the memory sends one-cycle pulses for four kinds of event: an uncorrectable error on a read, an uncorrectable error on a write, a correctable error on a read and a correctable error on a write. Each pulse comes with the address of the access that failed. Every event kind has a sticky flag. The block also keeps the address of the most recent failing access, but only while diagnostics are switched on.

Software reaches the block through a simple 32-bit register port, with a write strobe, a byte offset and write data. Read data is combinational and is taken from the offset currently presented. There are three registers. The flag register is read-only. The clear register takes write-one-to-clear commands and always reads zero. The address register is read-only and holds the captured address. Every other offset reads zero.

Top module: `memdiag_errcap`

## Requirements
- R1: After a synchronous active-low reset, all four flags are 0 and the captured address is 0.
- R2: An event pulse sets its flag, and the flag stays at 1 after the pulse ends until it is cleared.
- R3: A write to offset 0x8 clears each flag whose matching write-data bit is 1. Flags whose write-data bit is 0 keep their value.
- R4: A read of offset 0x8 returns 0.
- R5: A read of offset 0x0 returns the flags in these positions: bit 0 uncorrectable read, bit 1 uncorrectable write, bit 2 correctable read, bit 3 correctable write. Bits 31..4 read 0. The event input vector and the clear data use the same positions.
- R6: When at least one event pulse is present and diagnostics are on, the address register takes the address presented in that cycle on the next clock. Diagnostics are on when the 2-bit mode input equals 2'b11 or the separate test-enable input is 1.
- R7: While diagnostics are off, or when no event is present, the address register keeps its value.
- R8: If an event and a write-one clear of the same flag occur in the same cycle, the flag ends at 1.
- R9: If several events occur in one cycle, every matching flag is set, and the captured address is the address presented in that cycle.
- R10: Writes to offsets 0x0 and 0xC change nothing. Reads of any offset other than 0x0, 0x8 and 0xC return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_evt | input | 4 | One-cycle event pulses, in the flag-register bit positions |
| err_addr | input | 32 | Address of the failing access |
| test_mode | input | 2 | Diagnostic mode; 2'b11 enables capture |
| test_en | input | 1 | Separate capture enable |
| bus_wr | input | 1 | Register write strobe |
| bus_ofs | input | 4 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_ofs |

## Verification
The hardest case to reach from the ports is an event landing on a flag in the same cycle that software writes one to clear it, especially when other flags are being cleared and still others are already set. The bench reaches this by forcing every possible starting flag state in a single cycle: it applies that state as events together with a clear-all write, which works because set has priority. In the next cycle it applies every combination of event vector and clear mask. It also checks address capture against every value of the mode input combined with both values of the enable input.

// File: rtl/memdiag_pkg.sv
// Package: shared constants for the memory diagnostic error capture block.
// Assumes byte offsets and a fixed four-flag layout used by both the
// event inputs and the clear register data.
package memdiag_pkg;
    localparam int NUM_FLAGS = 4;

    // Flag bit positions (decoded by software, so fixed)
    localparam int FLG_UNC_RD = 0;
    localparam int FLG_UNC_WR = 1;
    localparam int FLG_COR_RD = 2;
    localparam int FLG_COR_WR = 3;

    // Register byte offsets
    localparam logic [3:0] OFS_FLAGS = 4'h0;
    localparam logic [3:0] OFS_CLEAR = 4'h8;
    localparam logic [3:0] OFS_EADDR = 4'hC;

    // Mode value that turns diagnostics on
    localparam logic [1:0] MODE_DIAG_ON = 2'b11;
endpackage

// File: rtl/memdiag_flag_bank.sv
// Module: memdiag_flag_bank
// A bank of sticky flags. A set pulse forces a flag to 1, a clear pulse
// forces it to 0, and set has priority over clear in the same cycle.
// Assumes set and clear are single-cycle qualified strobes.
module memdiag_flag_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        logic q;
        // Hold one sticky flag: set wins, then clear, else keep
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= 1'b0;
            else if (set_i[g])
                q <= 1'b1;
            else if (clr_i[g])
                q <= 1'b0;
        end
        assign flag_o[g] = q;
    end
endmodule

// File: rtl/memdiag_addr_capture.sv
// Module: memdiag_addr_capture
// Records the failing-access address when diagnostics are on and at least
// one event is reported; otherwise it holds the last captured value.
// Assumes the address is valid in the same cycle as the event pulses.
module memdiag_addr_capture #(
    parameter int N      = 4,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      evt_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        mode_i,
    input  logic              en_i,
    output logic [ADDR_W-1:0] cap_o
);
    import memdiag_pkg::*;

    logic diag_on;
    logic take;

    // Decide whether this cycle's address is captured
    always_comb begin
        diag_on = (mode_i == MODE_DIAG_ON) || en_i;
        take    = diag_on && (|evt_i);
    end

    // Hold the captured address register
    always_ff @(posedge clk) begin
        if (!rst_n)
            cap_o <= '0;
        else if (take)
            cap_o <= addr_i;
    end
endmodule

// File: rtl/memdiag_regif.sv
// Module: memdiag_regif
// Decodes the register port: produces clear strobes from writes to the
// clear register and multiplexes read data by offset. Writes to every
// other offset are dropped; unmapped offsets read zero.
module memdiag_regif #(
    parameter int N      = 4,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 4
) (
    input  logic              bus_wr,
    input  logic [OFS_W-1:0]  bus_ofs,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [N-1:0]      flag_i,
    input  logic [ADDR_W-1:0] cap_i,
    output logic [N-1:0]      clr_o,
    output logic [DATA_W-1:0] bus_rdata
);
    import memdiag_pkg::*;

    logic unused_wdata_hi;
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:N];

    // Turn a clear-register write into per-flag clear strobes
    always_comb begin
        clr_o = '0;
        if (bus_wr && (bus_ofs == OFS_W'(OFS_CLEAR)))
            clr_o = bus_wdata[N-1:0];
    end

    // Select read data for the presented offset
    always_comb begin
        bus_rdata = '0;
        if (bus_ofs == OFS_W'(OFS_FLAGS))
            bus_rdata[N-1:0] = flag_i;
        else if (bus_ofs == OFS_W'(OFS_EADDR))
            bus_rdata = DATA_W'(cap_i);
    end
endmodule

// File: rtl/memdiag_errcap.sv
// Module: memdiag_errcap (top)
// Memory diagnostic error capture: sticky error flags with write-one clear
// and a captured failing address gated by the diagnostic mode.
// Assumes event pulses last one cycle and follow the flag bit layout.
module memdiag_errcap #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [memdiag_pkg::NUM_FLAGS-1:0]  err_evt,
    input  logic [ADDR_W-1:0]                  err_addr,
    input  logic [1:0]                         test_mode,
    input  logic                               test_en,
    input  logic                               bus_wr,
    input  logic [OFS_W-1:0]                   bus_ofs,
    input  logic [DATA_W-1:0]                  bus_wdata,
    output logic [DATA_W-1:0]                  bus_rdata
);
    import memdiag_pkg::*;

    logic [NUM_FLAGS-1:0] flag_q;
    logic [NUM_FLAGS-1:0] clr_s;
    logic [ADDR_W-1:0]    cap_q;

    memdiag_regif #(
        .N(NUM_FLAGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFS_W(OFS_W)
    ) u_regif (
        .bus_wr   (bus_wr),
        .bus_ofs  (bus_ofs),
        .bus_wdata(bus_wdata),
        .flag_i   (flag_q),
        .cap_i    (cap_q),
        .clr_o    (clr_s),
        .bus_rdata(bus_rdata)
    );

    memdiag_flag_bank #(.N(NUM_FLAGS)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (err_evt),
        .clr_i (clr_s),
        .flag_o(flag_q)
    );

    memdiag_addr_capture #(.N(NUM_FLAGS), .ADDR_W(ADDR_W)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .evt_i (err_evt),
        .addr_i(err_addr),
        .mode_i(test_mode),
        .en_i  (test_en),
        .cap_o (cap_q)
    );
endmodule

// File: rtl/memdiag_errcap_chk.sv
// Module: memdiag_errcap_chk
// Property checker for memdiag_errcap, attached by bind. It observes the
// ports and the flag and address state.
module memdiag_errcap_chk #(
    parameter int N      = 4,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N-1:0]      err_evt,
    input logic [ADDR_W-1:0] err_addr,
    input logic [1:0]        test_mode,
    input logic              test_en,
    input logic              bus_wr,
    input logic [OFS_W-1:0]  bus_ofs,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [N-1:0]      flag_q,
    input logic [ADDR_W-1:0] cap_q
);
    logic diag;
    logic clr_wr;
    assign diag   = (test_mode == 2'b11) || test_en;
    assign clr_wr = bus_wr && (bus_ofs == OFS_W'(8));

    // R2, R8, R9: every event shows up as a set flag next cycle
    a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (err_evt != '0) |=> ((flag_q & $past(err_evt)) == $past(err_evt)));

    // R2: a flag rises only because of an event
    a_r2_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(err_evt)) == '0));

    // R3: a cleared flag without a simultaneous event ends at 0
    a_r3_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((flag_q & $past(bus_wdata[N-1:0]) & ~$past(err_evt)) == '0));

    // R3: without a clear write, a set flag stays set
    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

    // R4: the clear register reads zero
    a_r4_clear_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ofs == OFS_W'(8)) |-> (bus_rdata == '0));

    // R5: upper flag-register bits read zero
    a_r5_flag_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ofs == OFS_W'(0)) |-> (bus_rdata[DATA_W-1:N] == '0));

    // R6, R9: capture under diagnostics
    a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (diag && (err_evt != '0)) |=> (cap_q == $past(err_addr)));

    // R7: hold otherwise
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(diag && (err_evt != '0)) |=> $stable(cap_q));
endmodule

bind memdiag_errcap memdiag_errcap_chk #(
    .N(memdiag_pkg::NUM_FLAGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFS_W(OFS_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .err_evt  (err_evt),
    .err_addr (err_addr),
    .test_mode(test_mode),
    .test_en  (test_en),
    .bus_wr   (bus_wr),
    .bus_ofs  (bus_ofs),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .flag_q   (flag_q),
    .cap_q    (cap_q)
);

// File: tb/memdiag_errcap_test.sv
// Bench: memdiag_errcap_test. It sweeps the flag state, event and clear
// combinations exhaustively, and the mode and enable combinations for capture.
module memdiag_errcap_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  err_evt = '0;
    logic [31:0] err_addr = '0;
    logic [1:0]  test_mode = '0;
    logic        test_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_ofs = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    memdiag_errcap uut (
        .clk(clk), .rst_n(rst_n), .err_evt(err_evt), .err_addr(err_addr),
        .test_mode(test_mode), .test_en(test_en), .bus_wr(bus_wr),
        .bus_ofs(bus_ofs), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // one clock: inputs are driven at negedge, so advance to the next negedge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        err_evt = '0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic read(input logic [3:0] ofs, output logic [31:0] d);
        bus_ofs = ofs; bus_wr = 1'b0;
        #1 d = bus_rdata;
    endtask

    // Force flag state p in one cycle: events p plus clear-all (set wins)
    task automatic force_flags(input logic [3:0] p);
        err_evt = p; bus_wr = 1'b1; bus_ofs = 4'h8; bus_wdata = 32'hF;
        step();
        idle();
    endtask

    initial begin
        logic [31:0] d;
        logic [31:0] a0;
        @(negedge clk);
        step(); step();
        rst_n = 1'b1;
        // R1: reset state
        read(4'h0, d); check("R1 flags", d, 32'h0);
        read(4'hC, d); check("R1 address", d, 32'h0);

        // R3, R8, R9, R5: exhaustive prestate x events x clear mask
        for (int p = 0; p < 16; p++) begin
            for (int e = 0; e < 16; e++) begin
                for (int c = 0; c < 16; c++) begin
                    force_flags(4'(p));
                    err_evt = 4'(e); bus_wr = 1'b1; bus_ofs = 4'h8;
                    bus_wdata = {28'hABCDEF0, 4'(c)};
                    step();
                    idle();
                    read(4'h0, d);
                    check("R3/R8/R9 flags", d, 32'((p & ~c) | e));
                end
            end
        end

        // R2: sticky after pulse ends, for each single event
        for (int b = 0; b < 4; b++) begin
            force_flags(4'h0);
            err_evt = 4'(1 << b);
            step(); idle();
            step(); step();
            read(4'h0, d);
            check("R2 sticky bit", d, 32'(1 << b));
        end

        // R6, R7: capture for every mode and enable value
        for (int m = 0; m < 4; m++) begin
            for (int en = 0; en < 2; en++) begin
                a0 = 32'h1000_0000 + 32'(m * 16 + en);
                test_mode = 2'b11; test_en = 1'b0;
                err_evt = 4'h1; err_addr = a0;
                step(); idle();
                test_mode = 2'(m); test_en = 1'(en);
                err_evt = 4'h4; err_addr = ~a0;
                step(); idle();
                read(4'hC, d);
                check("R6/R7 capture gate", d, ((m == 3) || (en == 1)) ? ~a0 : a0);
            end
        end

        // R7: diagnostics on but no event keeps address
        test_mode = 2'b11; test_en = 1'b0;
        err_evt = 4'h2; err_addr = 32'hDEAD_BEEF;
        step(); idle();
        err_addr = 32'h1234_5678;
        step(); step();
        read(4'hC, d); check("R7 no event hold", d, 32'hDEAD_BEEF);

        // R9: multiple events in one cycle capture that address
        err_evt = 4'hF; err_addr = 32'hCAFE_0009;
        step(); idle();
        read(4'hC, d); check("R9 multi capture", d, 32'hCAFE_0009);
        read(4'h0, d); check("R9 multi flags", d, 32'hF);
        test_mode = 2'b00;

        // R10: writes to the flag and address registers do nothing
        bus_wr = 1'b1; bus_ofs = 4'h0; bus_wdata = 32'hFFFF_FFFF;
        step();
        bus_wr = 1'b1; bus_ofs = 4'hC; bus_wdata = 32'h0;
        step(); idle();
        read(4'h0, d); check("R10 flag write ignored", d, 32'hF);
        read(4'hC, d); check("R10 addr write ignored", d, 32'hCAFE_0009);

        // R4, R5, R10: read every offset
        for (int o = 0; o < 16; o++) begin
            read(4'(o), d);
            check("R4/R5/R10 read map", d,
                  (o == 0) ? 32'hF : (o == 12) ? 32'hCAFE_0009 : 32'h0);
        end

        // R1: reset clears everything again
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        read(4'h0, d); check("R1 flags after reset", d, 32'h0);
        read(4'hC, d); check("R1 addr after reset", d, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    // Watchdog
    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule